// File: doc/BRIEF.md
# Two-Wire Programming Command Slave

This block is the target side of a two-wire serial programming port. The port has a serial clock input and one data pin that can be driven both ways. The block brings both pins into the faster system clock through synchronisers and finds the serial clock edges there. It then shifts in 6-bit commands and turns each known command into a one-cycle strobe with a kind code. The load and read commands carry 16-clock data frames, which the block moves in or out.

The block also owns the word address that the commands act on. It holds two regions: program space, where the top address bit is 0, and configuration space, where the top address bit is 1. Incrementing the address never crosses from one region into the other. Decoded strobes, received words and the address go to the memory controller beside it. That controller supplies the word to be read and a code-protect flag. The high-voltage entry condition arrives as a plain `mode_en` level.

Top module: `pgm_cmd_slave`

## Requirements
- R1: A command is 6 bits sent least-significant bit first. Each bit is taken from the data pin at a falling edge of the serial clock. After the sixth bit, a known command produces exactly one `cmd_valid` pulse, lasting one system cycle, with its kind on `cmd_kind`.
- R2: The decode ignores the top command bit. The low five bits map to kinds as follows: 00h→0 load-config, 02h→1 load-program, 04h→2 read, 06h→3 increment, 16h→4 address-reset, 08h→5 internal-write, 18h→6 external-write-start, 0Ah→7 external-write-end, 09h→8 bulk-erase, 11h→9 row-erase. Any other code gives no strobe and leaves the address unchanged.
- R3: A load command (kind 0 or 1) is followed by a 16-clock frame: a start bit, 14 data bits sent LSB first, and a stop bit. After the stop bit, `data_valid` pulses once with the 14-bit word on `data_word`.
- R4: After a read command, `sdat_oe` rises following the first falling edge of the frame. Data bits 0 to 13 appear on `sdat_out` after rising edges 2 to 15. `sdat_oe` falls following the 16th falling edge. While `sdat_oe` is low, `sdat_out` is 0.
- R5: A read made while the address top bit is 0 and `code_prot` is high returns all zeros. Reads in configuration space return `rd_word` whatever the value of `code_prot`.
- R6: Load-config sets the address to the configuration base, which is only the top bit set (2000h at the default width). Address-reset sets the address to 0. No other command changes the address except increment.
- R7: Increment adds one within the current region. The top of program space (1FFFh) wraps to 0000h, and the top of configuration space (3FFFh) wraps to 2000h.
- R8: While `mode_en` is low, the address is held at 0 and no strobes or pin drive are produced. Entering the mode therefore starts at address 0.
- R9: Dropping `mode_en` during a command or frame discards the partial bits. The next complete command after re-entry decodes normally.
- R10: Under synchronous reset, `addr`, `data_word`, `cmd_valid`, `data_valid`, `sdat_oe` and `sdat_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Programming mode active level |
| sclk_in | input | 1 | Serial clock pin (asynchronous) |
| sdat_in | input | 1 | Data pin input value (asynchronous) |
| rd_word | input | 14 | Memory word at the current address |
| code_prot | input | 1 | Program space is read-protected |
| sdat_out | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_kind | output | 4 | Kind code of the strobed command |
| data_valid | output | 1 | One-cycle strobe for a received word |
| data_word | output | 14 | Last received data word |
| addr | output | 14 | Current word address |

## Verification
The assertions check these rules on every cycle: the address is held at zero and the pin is released outside the mode; load-config and address-reset produce their fixed addresses; an increment keeps the region bit; the address stays still without a strobe; strobes are single pulses with known kinds; and the output value is quiet while the driver is off. Other behaviour can only be shown by the bench's serial scenarios: bit order, the exact frame edges at which the pin is driven and released, zeroed protected reads against unprotected configuration reads, the two wrap points, and recovery after an aborted frame.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  localparam int CMD_W = 6;

  typedef enum logic [3:0] {
    K_LOAD_CFG  = 4'd0,
    K_LOAD_PGM  = 4'd1,
    K_READ      = 4'd2,
    K_INC       = 4'd3,
    K_RST       = 4'd4,
    K_WR_INT    = 4'd5,
    K_WR_EXT    = 4'd6,
    K_WR_END    = 4'd7,
    K_ERASE_ALL = 4'd8,
    K_ERASE_ROW = 4'd9,
    K_NONE      = 4'd15
  } cmd_kind_e;

  // Top command bit is a don't-care; only the low five bits select the kind.
  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-2:0] c);
    case (c)
      5'h00:   return K_LOAD_CFG;
      5'h02:   return K_LOAD_PGM;
      5'h04:   return K_READ;
      5'h06:   return K_INC;
      5'h16:   return K_RST;
      5'h08:   return K_WR_INT;
      5'h18:   return K_WR_EXT;
      5'h0A:   return K_WR_END;
      5'h09:   return K_ERASE_ALL;
      5'h11:   return K_ERASE_ROW;
      default: return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pgm_frame_engine.sv
module pgm_frame_engine
  import pgm_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              sclk_lvl,
  input  logic              sdat_lvl,
  input  logic              addr_top,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              code_prot,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_word,
  output logic              sdat_out,
  output logic              sdat_oe
);

  localparam int PAY_LEN = DATA_W + 2;
  localparam int CNT_MAX = (PAY_LEN > CMD_W) ? PAY_LEN : CMD_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_PAY  = CNT_W'(PAY_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);

  typedef enum logic [1:0] {S_CMD, S_WDATA, S_RDATA} state_e;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] wr_sr;
  logic [DATA_W-1:0] rd_sr;
  logic              sclk_prev;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [CMD_W-1:0]  cmd_next;
  cmd_kind_e         kind_next;
  logic              in_data;

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign cmd_next  = {sdat_lvl, cmd_sr[CMD_W-1:1]};
  assign kind_next = decode_cmd(cmd_next[CMD_W-2:0]);
  assign in_data   = (cnt != '0) && (cnt <= LAST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !mode_en) begin
      state      <= S_CMD;
      cnt        <= '0;
      cmd_sr     <= '0;
      wr_sr      <= '0;
      rd_sr      <= '0;
      cmd_valid  <= 1'b0;
      cmd_kind   <= K_NONE;
      data_valid <= 1'b0;
      sdat_out   <= 1'b0;
      sdat_oe    <= 1'b0;
      if (rst) data_word <= '0;
    end else begin
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      case (state)
        S_CMD: begin
          if (sclk_fall) begin
            cmd_sr <= cmd_next;
            if (cnt == LAST_CMD) begin
              cnt <= '0;
              if (kind_next != K_NONE) begin
                cmd_valid <= 1'b1;
                cmd_kind  <= kind_next;
              end
              if (kind_next == K_LOAD_CFG || kind_next == K_LOAD_PGM) begin
                state <= S_WDATA;
              end else if (kind_next == K_READ) begin
                state <= S_RDATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_WDATA: begin
          if (sclk_fall) begin
            if (in_data) wr_sr <= {sdat_lvl, wr_sr[DATA_W-1:1]};
            if (cnt == LAST_PAY) begin
              data_valid <= 1'b1;
              data_word  <= wr_sr;
              state      <= S_CMD;
              cnt        <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_RDATA: begin
          if (sclk_fall) begin
            if (cnt == '0) begin
              sdat_oe  <= 1'b1;
              sdat_out <= 1'b0;
              rd_sr    <= (code_prot && !addr_top) ? '0 : rd_word;
            end
            if (cnt == LAST_PAY) begin
              sdat_oe  <= 1'b0;
              sdat_out <= 1'b0;
              state    <= S_CMD;
              cnt      <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (sclk_rise) begin
            if (in_data) begin
              sdat_out <= rd_sr[0];
              rd_sr    <= rd_sr >> 1;
            end else begin
              sdat_out <= 1'b0;
            end
          end
        end
        default: state <= S_CMD;
      endcase
    end
  end

endmodule

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_kind,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W - 1);

  always_ff @(posedge clk) begin
    if (rst || !mode_en) begin
      addr <= '0;
    end else if (cmd_valid) begin
      case (cmd_kind_e'(cmd_kind))
        K_LOAD_CFG: addr <= CFG_BASE;
        K_RST:      addr <= '0;
        K_INC:      addr <= {addr[ADDR_W-1], addr[ADDR_W-2:0] + 1'b1};
        default:    addr <= addr;
      endcase
    end
  end

endmodule

// File: rtl/pgm_cmd_slave.sv
module pgm_cmd_slave #(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              sclk_in,
  input  logic              sdat_in,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              code_prot,
  output logic              sdat_out,
  output logic              sdat_oe,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_word,
  output logic [ADDR_W-1:0] addr
);

  logic [1:0] pins_sync;

  pgm_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({sdat_in, sclk_in}),
    .dout (pins_sync)
  );

  pgm_frame_engine #(.DATA_W(DATA_W)) eng_i (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .sclk_lvl   (pins_sync[0]),
    .sdat_lvl   (pins_sync[1]),
    .addr_top   (addr[ADDR_W-1]),
    .rd_word    (rd_word),
    .code_prot  (code_prot),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .data_valid (data_valid),
    .data_word  (data_word),
    .sdat_out   (sdat_out),
    .sdat_oe    (sdat_oe)
  );

  pgm_addr_ctr #(.ADDR_W(ADDR_W)) actr_i (
    .clk       (clk),
    .rst       (rst),
    .mode_en   (mode_en),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .addr      (addr)
  );

endmodule

// File: rtl/pgm_cmd_slave_chk.sv
module pgm_cmd_slave_chk
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_en,
  input logic              cmd_valid,
  input logic [3:0]        cmd_kind,
  input logic              data_valid,
  input logic              sdat_oe,
  input logic              sdat_out,
  input logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(1) << (ADDR_W - 1);

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_known_kind_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_kind <= 4'd9));

  assert_word_alone_R3: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (!cmd_valid && !sdat_oe));

  assert_quiet_pin_R4: assert property (@(posedge clk) disable iff (rst)
    !sdat_oe |-> !sdat_out);

  assert_load_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_en && cmd_valid && cmd_kind == K_LOAD_CFG) |=> (addr == CFG_BASE));

  assert_addr_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_en && cmd_valid && cmd_kind == K_RST) |=> (addr == '0));

  assert_region_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_en && cmd_valid && cmd_kind == K_INC) |=> (addr[ADDR_W-1] == $past(addr[ADDR_W-1])));

  assert_addr_still_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_en && !cmd_valid) |=> $stable(addr));

  assert_mode_off_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (addr == '0 && !sdat_oe && !cmd_valid && !data_valid));

endmodule

bind pgm_cmd_slave pgm_cmd_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode_en    (mode_en),
  .cmd_valid  (cmd_valid),
  .cmd_kind   (cmd_kind),
  .data_valid (data_valid),
  .sdat_oe    (sdat_oe),
  .sdat_out   (sdat_out),
  .addr       (addr)
);

// File: tb/pgm_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module pgm_cmd_slave_tb_top;

  localparam int AW = 8;
  localparam int DW = 14;
  localparam logic [AW-1:0] BASE = 8'h80;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode_en;
  logic          sclk;
  logic          sdat;
  logic [DW-1:0] rd_word;
  logic          code_prot;
  logic          sdat_out;
  logic          sdat_oe;
  logic          cmd_valid;
  logic [3:0]    cmd_kind;
  logic          data_valid;
  logic [DW-1:0] data_word;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int n_cmd  = 0;
  int n_data = 0;
  logic [3:0]    last_kind = 4'hF;
  logic [DW-1:0] last_data = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign rd_word = 14'h2A5A ^ {6'd0, addr};

  pgm_cmd_slave #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .sclk_in    (sclk),
    .sdat_in    (sdat),
    .rd_word    (rd_word),
    .code_prot  (code_prot),
    .sdat_out   (sdat_out),
    .sdat_oe    (sdat_oe),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .data_valid (data_valid),
    .data_word  (data_word),
    .addr       (addr)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++;
      last_kind = cmd_kind;
    end
    if (data_valid) begin
      n_data++;
      last_data = data_word;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b1;
    repeat (2) @(posedge clk);
    #1 sdat = b;
    repeat (3) @(posedge clk);
    #1 sclk = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) send_bit(c[i]);
    repeat (4) @(posedge clk);
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(w[i]);
    send_bit(1'b0);
    repeat (4) @(posedge clk);
  endtask

  task automatic read_word(output logic [DW-1:0] got, output logic [15:0] oe_seen);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      oe_seen[i] = sdat_oe;
      if (i >= 1 && i <= DW) got[i-1] = sdat_out;
      sclk = 1'b0;
      repeat (5) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  // {cmd, expected kind, payload word, expected address (low AW bits)}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {6'h06, 4'd3, 14'h0000, 14'h0001},
    {6'h26, 4'd3, 14'h0000, 14'h0002},
    {6'h02, 4'd1, 14'h1234, 14'h0002},
    {6'h00, 4'd0, 14'h0ABC, 14'h0080},
    {6'h06, 4'd3, 14'h0000, 14'h0081},
    {6'h16, 4'd4, 14'h0000, 14'h0000},
    {6'h08, 4'd5, 14'h0000, 14'h0000},
    {6'h18, 4'd6, 14'h0000, 14'h0000},
    {6'h0A, 4'd7, 14'h0000, 14'h0000},
    {6'h09, 4'd8, 14'h0000, 14'h0000},
    {6'h31, 4'd9, 14'h0000, 14'h0000},
    {6'h22, 4'd1, 14'h3FC1, 14'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    logic [15:0]   oe_seen;
    int            c0;
    int            d0;
    rst = 1'b1; mode_en = 1'b0; sclk = 1'b0; sdat = 1'b0; code_prot = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 addr", addr, 0);
    check("R10 oe", sdat_oe, 0);
    check("R10 out", sdat_out, 0);
    check("R10 strobes", {cmd_valid, data_valid}, 0);
    check("R10 word", data_word, 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1 mode_en = 1'b1;
    repeat (3) @(posedge clk);
    check("R8 entry addr", addr, 0);

    // Table walk: R1 R2 R3 R6 R7
    for (int v = 0; v < NV; v++) begin
      c0 = n_cmd;
      d0 = n_data;
      send_cmd(VEC[v][37:32]);
      if (VEC[v][31:28] <= 4'd1) begin
        send_word(VEC[v][27:14]);
        check("R3 word", last_data, VEC[v][27:14]);
        check("R3 count", n_data - d0, 1);
      end
      check("R1 one strobe", n_cmd - c0, 1);
      check("R2 kind", last_kind, VEC[v][31:28]);
      check("R6 R7 addr", addr, VEC[v][AW-1:0]);
    end

    // R2 unknown code: no strobe, address unchanged
    send_cmd(6'h06);
    c0 = n_cmd;
    send_cmd(6'h03);
    check("R2 unknown no strobe", n_cmd - c0, 0);
    check("R2 unknown addr", addr, 1);

    // R4 read unprotected in program space
    send_cmd(6'h04);
    read_word(got, oe_seen);
    check("R4 read data", got, 14'h2A5A ^ 14'h0001);
    check("R4 oe pattern", oe_seen, 16'hFFFE);
    check("R4 oe released", sdat_oe, 0);
    check("R4 out quiet", sdat_out, 0);

    // R5 protected program read returns zero
    code_prot = 1'b1;
    send_cmd(6'h04);
    read_word(got, oe_seen);
    check("R5 protected read", got, 0);
    check("R5 protected oe", oe_seen, 16'hFFFE);

    // R5 config space not affected by protection
    send_cmd(6'h00);
    send_word(14'h0155);
    send_cmd(6'h04);
    read_word(got, oe_seen);
    check("R5 config read", got, 14'h2A5A ^ 14'h0080);
    code_prot = 1'b0;

    // R7 program region wrap
    send_cmd(6'h16);
    for (int i = 0; i < 127; i++) send_cmd(6'h06);
    check("R7 program top", addr, 8'h7F);
    send_cmd(6'h06);
    check("R7 program wrap", addr, 8'h00);

    // R7 config region wrap
    send_cmd(6'h00);
    send_word(14'h0000);
    for (int i = 0; i < 127; i++) send_cmd(6'h06);
    check("R7 config top", addr, 8'hFF);
    send_cmd(6'h06);
    check("R7 config wrap", addr, BASE);

    // R8 leaving the mode clears the address
    #1 mode_en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R8 addr held zero", addr, 0);
    check("R8 oe off", sdat_oe, 0);
    mode_en = 1'b1;
    repeat (3) @(posedge clk);

    // R9 abort mid-command and mid-frame
    send_cmd(6'h06);
    send_cmd(6'h06);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    #1 mode_en = 1'b0;
    repeat (4) @(posedge clk);
    #1 mode_en = 1'b1;
    repeat (3) @(posedge clk);
    c0 = n_cmd;
    send_cmd(6'h06);
    check("R9 clean decode", n_cmd - c0, 1);
    check("R9 addr after abort", addr, 1);
    send_cmd(6'h02);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    #1 mode_en = 1'b0;
    repeat (4) @(posedge clk);
    #1 mode_en = 1'b1;
    repeat (3) @(posedge clk);
    d0 = n_data;
    send_cmd(6'h06);
    check("R9 frame discarded", n_data - d0, 0);
    check("R9 kind after frame abort", last_kind, 3);
    check("R9 addr after frame abort", addr, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule